// File: doc/BRIEF.md
# Sequential restoring divider

This block divides one unsigned 32-bit integer by another using the restoring shift-and-subtract method, producing one quotient bit per clock. A single double-width working register holds the partial remainder in its upper half and the dividend in its lower half. Each step moves the register one place left, tries to take the divisor away from the upper half, and shifts a 1 into the bottom when the trial fits or leaves the upper half untouched and shifts in a 0 when it does not. After 32 steps the lower half is the quotient, and the upper half, moved back one place to the right, is the remainder.

A caller presents the two operands together with a one-cycle start pulse. The operands are captured on that edge, and the block runs on its own until it raises done. The results stay on the outputs until the next accepted start. A start that arrives while a division is running is dropped, and a zero divisor finishes in the normal time with a fixed result.

Top module: `seq_restoring_divider`

## Requirements
- R1: While rst_n is low, done, quotient and remainder are all 0, and they stay 0 after reset is released until a start is accepted.
- R2: A start seen while the block is idle is accepted. done drops to 0 on the accepting clock edge and rises on the 32nd rising edge after it.
- R3: For a nonzero divisor, quotient equals the dividend divided by the divisor, rounded down, with both operands treated as unsigned.
- R4: For a nonzero divisor, remainder equals the dividend minus quotient times divisor, and is smaller than the divisor.
- R5: A divisor of 0 gives a quotient of all ones (0xFFFFFFFF) and a remainder equal to the dividend, and done rises on the same schedule as in R2.
- R6: A start that arrives while a division is in progress has no effect: the running result and its done timing are unchanged.
- R7: The operands are sampled only on the accepting edge. Later changes to dividend or divisor do not alter the result.
- R8: Operands with bit 31 set (for example a divisor of 0x80000001) divide correctly, because the fit test uses the borrow of a 33-bit subtraction.
- R9: Once done is high, it and both results hold steady until the next start, regardless of changes on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands (taken only when idle) |
| dividend | input | 32 | Unsigned number to be divided |
| divisor | input | 32 | Unsigned number to divide by |
| done | output | 1 | High when the results are valid, until the next accepted start |
| quotient | output | 32 | Unsigned quotient |
| remainder | output | 32 | Unsigned remainder |

## Verification
A vector table covers several kinds of operands:
- small textbook cases such as 29/3;
- a dividend smaller than the divisor, which yields a zero quotient and returns the dividend as the remainder;
- exact multiples and powers of two, which separate errors in the quotient bits from errors in the remainder path;
- operands with the top bit set, which expose a fit test that reads the top bit of the partial remainder as a sign.

Directed cases then cover:
- a zero divisor, with a zero and with a nonzero dividend;
- a second start and operand changes during a running division;
- operand changes after completion;
- a reset in the middle of a division.

Each directed case separates a correct result from one that is restarted, re-sampled or lost.

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2*W-1:0] acc_q;
  logic           ext_q;
  logic [W-1:0]   dvs_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;

  wire [W:0]   trial  = {ext_q, acc_q[2*W-1:W]};
  wire [W+1:0] diff   = {1'b0, trial} - {2'b00, dvs_q};
  wire         fits   = ~diff[W+1];
  wire [W-1:0] kept   = fits ? diff[W-1:0] : acc_q[2*W-1:W];
  wire         accept = start & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      ext_q  <= 1'b0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (accept) begin
      acc_q  <= {{(W-1){1'b0}}, dividend, 1'b0};
      ext_q  <= 1'b0;
      dvs_q  <= divisor;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      {ext_q, acc_q} <= {kept, acc_q[W-1:0], fits};
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign quotient  = acc_q[W-1:0];
  assign remainder = {ext_q, acc_q[2*W-1:W+1]};

  logic [W-1:0] chk_a, chk_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_a <= '0;
      chk_b <= '0;
    end else if (accept) begin
      chk_a <= dividend;
      chk_b <= divisor;
    end
  end

  assert_done_from_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy_q));

  assert_reconstruct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && chk_b != '0) |->
      ({{W{1'b0}}, quotient} * {{W{1'b0}}, chk_b} + {{W{1'b0}}, remainder}) == {{W{1'b0}}, chk_a});

  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && chk_b != '0) |-> remainder < chk_b);

  assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && chk_b == '0) |-> (quotient == '1 && remainder == chk_a));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));

  assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(quotient) && $stable(remainder)));
endmodule

// File: tb/seq_restoring_divider_tb.sv
`timescale 1ns/1ps
module seq_restoring_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        done;
  logic [31:0] quotient, remainder;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  seq_restoring_divider #(.W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .done(done), .quotient(quotient), .remainder(remainder)
  );

  // {dividend, divisor, quotient, remainder}
  localparam logic [127:0] VEC [12] = '{
    {32'd29,         32'd3,          32'd9,          32'd2},
    {32'd100,        32'd7,          32'd14,         32'd2},
    {32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
    {32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0},
    {32'hFFFFFFFF,   32'h80000001,   32'd1,          32'h7FFFFFFE},
    {32'h80000000,   32'h80000000,   32'd1,          32'd0},
    {32'd5,          32'd9,          32'd0,          32'd5},
    {32'd0,          32'd12,         32'd0,          32'd0},
    {32'h12345678,   32'h00000100,   32'h00123456,   32'h00000078},
    {32'd1000000,    32'd1000,       32'd1000,       32'd0},
    {32'hFFFFFFFE,   32'd2,          32'h7FFFFFFF,   32'd0},
    {32'hDEADBEEF,   32'h00010000,   32'h0000DEAD,   32'h0000BEEF}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(inout int lat);
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, output int lat);
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    wait_done(lat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 100000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] hq, hr;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
    check(quotient == '0 && remainder == '0, "R1 outputs in reset", quotient, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after release", {31'd0, done}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      run_op(VEC[i][127:96], VEC[i][95:64], lat);
      check(lat == 32, "R2 done latency", lat, 32);
      check(quotient == VEC[i][63:32], (i == 4 || i == 5) ? "R8 quotient" : "R3 quotient", quotient, VEC[i][63:32]);
      check(remainder == VEC[i][31:0], (i == 4 || i == 5) ? "R8 remainder" : "R4 remainder", remainder, VEC[i][31:0]);
    end

    // R2: done falls on the accepting edge
    @(negedge clk);
    dividend = 32'd50; divisor = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done cleared by start", {31'd0, done}, 32'd0);
    lat = 0;
    wait_done(lat);
    check(quotient == 32'd10 && remainder == 32'd0, "R3 quotient 50/5", quotient, 32'd10);

    // R5: zero divisor
    run_op(32'h0BADF00D, 32'd0, lat);
    check(lat == 32, "R5 latency", lat, 32);
    check(quotient == 32'hFFFFFFFF, "R5 quotient", quotient, 32'hFFFFFFFF);
    check(remainder == 32'h0BADF00D, "R5 remainder", remainder, 32'h0BADF00D);
    run_op(32'd0, 32'd0, lat);
    check(quotient == 32'hFFFFFFFF && remainder == 32'd0, "R5 zero over zero", remainder, 32'd0);

    // R6 and R7: second start and operand changes while running
    @(negedge clk);
    dividend = 32'd29; divisor = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (5) begin @(negedge clk); lat++; end
    dividend = 32'd1000; divisor = 32'd7; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    dividend = 32'hFFFF0000; divisor = 32'd1;
    wait_done(lat);
    check(lat == 32, "R6 latency unchanged", lat, 32);
    check(quotient == 32'd9, "R6 quotient kept", quotient, 32'd9);
    check(remainder == 32'd2, "R7 remainder kept", remainder, 32'd2);

    // R9: hold after done
    hq = quotient; hr = remainder;
    dividend = 32'h55555555; divisor = 32'h3;
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R9 done held", {31'd0, done}, 32'd1);
    check(quotient == hq, "R9 quotient held", quotient, hq);
    check(remainder == hr, "R9 remainder held", remainder, hr);

    // R1: reset in the middle of a division
    @(negedge clk);
    dividend = 32'd77; divisor = 32'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(done == 1'b0 && quotient == '0 && remainder == '0, "R1 reset mid-run", quotient, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(done == 1'b0, "R1 no done after reset", {31'd0, done}, 32'd0);
    run_op(32'd77, 32'd4, lat);
    check(quotient == 32'd19 && remainder == 32'd1, "R3 after reset", quotient, 32'd19);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule